// File: doc/BRIEF.md
# Watchdog Timer with Delayed Reset

This block is a watchdog built around an up-counter that advances on a watchdog clock tick. A select field picks one of eight timeout intervals, each a power of two. The interval grows by a fixed exponent step for each select value. When the chosen interval runs out, the block raises an interrupt flag and a one-cycle wakeup pulse. It then opens a grace window of a fixed number of ticks. If software has not restarted the count by the end of that window, and the reset function is enabled, the block drives a system reset pulse of fixed length. After the pulse it begins counting again from zero.

Software controls the block through a small control word: counting enable, interrupt enable, reset enable and interval select. It also has two strobes: one restarts the count and one clears the interrupt flag. Writes of any kind take effect only while the protection input is held open. Default parameters give an 18-bit counter, intervals from 16 to 2^18 ticks, a 1024-tick grace window and a 4-tick reset pulse.

Top module: `wdt_grace`

## Requirements
- R1: After reset, irq_o, rst_o, wake_o and flag_o are 0 and cnt_o is 0. The stored control word is cleared: counting disabled, interrupt disabled, reset disabled, select 0.
- R2: The control word is loaded on a clock edge only when cfg_wr_i and unlock_i are both 1. A count-clear or flag-clear strobe is acted on only while unlock_i is 1. Otherwise the strobe changes neither the count nor the flag.
- R3: While counting is enabled, cnt_o increments by one on each clock edge where tick_i is 1, and it holds on edges where tick_i is 0.
- R4: With select value n, the timeout occurs on the 2^(BASE_EXP + EXP_STEP*n)-th tick after a restart. cnt_o reaches that count minus one just before the timeout. At the timeout edge, flag_o is set, wake_o pulses for exactly one cycle and cnt_o returns to 0.
- R5: irq_o is 1 exactly when flag_o is 1 and interrupt enable is 1. flag_o stays set until a permitted flag-clear strobe clears it. A timeout on the same edge as a clear leaves the flag set.
- R6: With reset enabled, rst_o rises on the GRACE-th tick after the timeout and stays high for RST_LEN ticks. Counting then restarts from zero, and flag_o is left unchanged.
- R7: With reset disabled, rst_o stays 0 and the block waits at the end of the grace window. If reset enable is later written to 1, rst_o rises on the next tick.
- R8: A permitted count-clear strobe restarts the count from zero during counting or during the grace window, so neither the timeout nor the reset occurs on the old schedule. It takes priority over a tick on the same edge and does not change flag_o.
- R9: A permitted control write that changes the select value restarts the count from zero. A write with an unchanged select lets the count continue.
- R10: Clearing the counting enable returns the block to idle on the next edge: cnt_o 0, any grace window dropped and any reset pulse ended. No reset follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Watchdog clock tick; counting advances on edges where it is 1 |
| unlock_i | input | 1 | Write protection open when 1 |
| cfg_wr_i | input | 1 | Control word write strobe |
| cfg_en_i | input | 1 | Counting enable value to write |
| cfg_irq_en_i | input | 1 | Interrupt enable value to write |
| cfg_rst_en_i | input | 1 | Reset enable value to write |
| cfg_sel_i | input | SEL_W | Interval select value to write |
| clr_cnt_i | input | 1 | Count restart strobe |
| clr_flag_i | input | 1 | Interrupt flag clear strobe |
| irq_o | output | 1 | Interrupt request |
| rst_o | output | 1 | System reset pulse |
| wake_o | output | 1 | One-cycle wakeup request at the timeout |
| flag_o | output | 1 | Timeout status flag |
| cnt_o | output | CNT_W | Current count value |

## Verification
The bench runs through all eight select values on a reduced configuration. For each one it checks the tick on which the timeout lands, the tick on which the reset starts and the tick on which it ends. An off-by-one in the interval table or in the grace count would move one of these edges by a cycle. Other directed cases cover several interactions. A flag clear arriving on the timeout edge must leave the flag set; a design that orders the clear after the set would lose it. A count restart inside the grace window must stop the pending reset. Writing reset enable after the window has run out must bring the reset on the next tick. A rewrite with an unchanged select must not restart the count, which a design that restarts on every write would get wrong. Writes and strobes made while the protection is closed must leave the count and the flag untouched.

// File: rtl/wdt_grace_pkg.sv
package wdt_grace_pkg;

    typedef enum logic [1:0] {
        PH_COUNT = 2'd0,
        PH_GRACE = 2'd1,
        PH_RESET = 2'd2
    } wdt_phase_e;

    // exponent of the interval for a given select index
    function automatic int unsigned interval_exp(input int unsigned base,
                                                 input int unsigned step,
                                                 input int unsigned idx);
        return base + step * idx;
    endfunction

endpackage

// File: rtl/wdt_grace_ctlreg.sv
module wdt_grace_ctlreg #(
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unlock_i,
    input  logic             cfg_wr_i,
    input  logic             cfg_en_i,
    input  logic             cfg_irq_en_i,
    input  logic             cfg_rst_en_i,
    input  logic [SEL_W-1:0] cfg_sel_i,
    output logic             en_o,
    output logic             ie_o,
    output logic             re_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             sel_chg_o
);

    typedef struct packed {
        logic             en;
        logic             ie;
        logic             re;
        logic [SEL_W-1:0] sel;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic accept;

    always_comb begin
        accept = cfg_wr_i && unlock_i;
        ctl_d  = ctl_q;
        if (accept) begin
            ctl_d.en  = cfg_en_i;
            ctl_d.ie  = cfg_irq_en_i;
            ctl_d.re  = cfg_rst_en_i;
            ctl_d.sel = cfg_sel_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign en_o      = ctl_q.en;
    assign ie_o      = ctl_q.ie;
    assign re_o      = ctl_q.re;
    assign sel_o     = ctl_q.sel;
    assign sel_chg_o = accept && (cfg_sel_i != ctl_q.sel);

endmodule

// File: rtl/wdt_grace_limit.sv
module wdt_grace_limit
    import wdt_grace_pkg::*;
#(
    parameter int unsigned CNT_W    = 18,
    parameter int unsigned SEL_W    = 3,
    parameter int unsigned BASE_EXP = 4,
    parameter int unsigned EXP_STEP = 2
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [CNT_W-1:0] last_o
);

    localparam int unsigned NSEL = 1 << SEL_W;

    logic [CNT_W-1:0] last_tab [NSEL];

    for (genvar i = 0; i < NSEL; i++) begin : g_tab
        localparam int unsigned    EXP  = interval_exp(BASE_EXP, EXP_STEP, i);
        localparam logic [CNT_W:0] SPAN = (CNT_W+1)'(1) << EXP;
        assign last_tab[i] = CNT_W'(SPAN - 1'b1);
    end

    assign last_o = last_tab[sel_i];

endmodule

// File: rtl/wdt_grace.sv
module wdt_grace
    import wdt_grace_pkg::*;
#(
    parameter int unsigned CNT_W    = 18,
    parameter int unsigned SEL_W    = 3,
    parameter int unsigned BASE_EXP = 4,
    parameter int unsigned EXP_STEP = 2,
    parameter int unsigned GRACE    = 1024,
    parameter int unsigned RST_LEN  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             unlock_i,
    input  logic             cfg_wr_i,
    input  logic             cfg_en_i,
    input  logic             cfg_irq_en_i,
    input  logic             cfg_rst_en_i,
    input  logic [SEL_W-1:0] cfg_sel_i,
    input  logic             clr_cnt_i,
    input  logic             clr_flag_i,
    output logic             irq_o,
    output logic             rst_o,
    output logic             wake_o,
    output logic             flag_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam int unsigned GRC_W = (GRACE > 1) ? $clog2(GRACE) : 1;
    localparam int unsigned RLN_W = $clog2(RST_LEN + 1);
    localparam logic [GRC_W-1:0] GRC_LAST = GRC_W'(GRACE - 1);
    localparam logic [RLN_W-1:0] RLN_LAST = RLN_W'(RST_LEN - 1);

    typedef struct packed {
        wdt_phase_e       phase;
        logic [CNT_W-1:0] cnt;
        logic [GRC_W-1:0] grc;
        logic [RLN_W-1:0] rln;
        logic             flag;
        logic             wake;
    } st_t;

    logic             en_q, ie_q, re_q, sel_chg;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] last_cnt;
    logic             restart;
    st_t              st_d, st_q;

    wdt_grace_ctlreg #(.SEL_W(SEL_W)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .unlock_i     (unlock_i),
        .cfg_wr_i     (cfg_wr_i),
        .cfg_en_i     (cfg_en_i),
        .cfg_irq_en_i (cfg_irq_en_i),
        .cfg_rst_en_i (cfg_rst_en_i),
        .cfg_sel_i    (cfg_sel_i),
        .en_o         (en_q),
        .ie_o         (ie_q),
        .re_o         (re_q),
        .sel_o        (sel_q),
        .sel_chg_o    (sel_chg)
    );

    wdt_grace_limit #(
        .CNT_W    (CNT_W),
        .SEL_W    (SEL_W),
        .BASE_EXP (BASE_EXP),
        .EXP_STEP (EXP_STEP)
    ) u_lim (
        .sel_i  (sel_q),
        .last_o (last_cnt)
    );

    always_comb begin
        restart   = (clr_cnt_i && unlock_i) || sel_chg;
        st_d      = st_q;
        st_d.wake = 1'b0;
        if (clr_flag_i && unlock_i) st_d.flag = 1'b0;

        if (!en_q) begin
            st_d.phase = PH_COUNT;
            st_d.cnt   = '0;
            st_d.grc   = '0;
            st_d.rln   = '0;
        end else if (restart && st_q.phase != PH_RESET) begin
            st_d.phase = PH_COUNT;
            st_d.cnt   = '0;
            st_d.grc   = '0;
        end else if (tick_i) begin
            unique case (st_q.phase)
                PH_COUNT: begin
                    if (st_q.cnt == last_cnt) begin
                        st_d.phase = PH_GRACE;
                        st_d.cnt   = '0;
                        st_d.grc   = '0;
                        st_d.flag  = 1'b1;
                        st_d.wake  = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_GRACE: begin
                    if (st_q.grc == GRC_LAST) begin
                        if (re_q) begin
                            st_d.phase = PH_RESET;
                            st_d.rln   = '0;
                        end
                    end else begin
                        st_d.grc = st_q.grc + 1'b1;
                    end
                end
                PH_RESET: begin
                    if (st_q.rln == RLN_LAST) begin
                        st_d.phase = PH_COUNT;
                        st_d.cnt   = '0;
                        st_d.grc   = '0;
                    end else begin
                        st_d.rln = st_q.rln + 1'b1;
                    end
                end
                default: st_d.phase = PH_COUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_COUNT, default: '0};
        else        st_q <= st_d;
    end

    assign irq_o  = st_q.flag && ie_q;
    assign rst_o  = (st_q.phase == PH_RESET);
    assign wake_o = st_q.wake;
    assign flag_o = st_q.flag;
    assign cnt_o  = st_q.cnt;

endmodule

// File: rtl/wdt_grace_chk.sv
module wdt_grace_chk #(
    parameter int unsigned CNT_W = 18,
    parameter int unsigned SEL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             unlock_i,
    input logic             cfg_wr_i,
    input logic             clr_cnt_i,
    input logic             en_q,
    input logic             ie_q,
    input logic             re_q,
    input logic [SEL_W-1:0] sel_q,
    input logic [CNT_W-1:0] last_cnt,
    input logic             rst_o,
    input logic             wake_o,
    input logic             flag_o,
    input logic [CNT_W-1:0] cnt_o
);

    assert_locked_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && !unlock_i) |=> $stable({en_q, ie_q, re_q, sel_q}));

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= last_cnt);

    assert_wake_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);

    assert_wake_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> flag_o);

    assert_no_reset_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!re_q && !rst_o) |=> !rst_o);

    assert_clear_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock_i && clr_cnt_i && !rst_o) |=> (cnt_o == '0));

    assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (cnt_o == '0 && !rst_o));

endmodule

bind wdt_grace wdt_grace_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .unlock_i  (unlock_i),
    .cfg_wr_i  (cfg_wr_i),
    .clr_cnt_i (clr_cnt_i),
    .en_q      (en_q),
    .ie_q      (ie_q),
    .re_q      (re_q),
    .sel_q     (sel_q),
    .last_cnt  (last_cnt),
    .rst_o     (rst_o),
    .wake_o    (wake_o),
    .flag_o    (flag_o),
    .cnt_o     (cnt_o)
);

// File: tb/wdt_grace_test.sv
module wdt_grace_test;

    localparam int CNT_W = 9;
    localparam int SEL_W = 3;
    localparam int BASE  = 2;
    localparam int STEP  = 1;
    localparam int G     = 16;
    localparam int RL    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1, unlock = 1'b0, cfg_wr = 1'b0;
    logic en_in = 1'b0, ie_in = 1'b0, re_in = 1'b0;
    logic [SEL_W-1:0] sel_in = '0;
    logic clr_cnt = 1'b0, clr_flag = 1'b0;
    logic irq, rst, wake, flag;
    logic [CNT_W-1:0] cnt;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdt_grace #(
        .CNT_W(CNT_W), .SEL_W(SEL_W), .BASE_EXP(BASE), .EXP_STEP(STEP),
        .GRACE(G), .RST_LEN(RL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .unlock_i(unlock),
        .cfg_wr_i(cfg_wr), .cfg_en_i(en_in), .cfg_irq_en_i(ie_in),
        .cfg_rst_en_i(re_in), .cfg_sel_i(sel_in), .clr_cnt_i(clr_cnt),
        .clr_flag_i(clr_flag), .irq_o(irq), .rst_o(rst), .wake_o(wake),
        .flag_o(flag), .cnt_o(cnt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input logic e, input logic i, input logic r, input int s);
        en_in = e; ie_in = i; re_in = r; sel_in = SEL_W'(s);
        cfg_wr = 1'b1; unlock = 1'b1;
        adv(1);
        cfg_wr = 1'b0; unlock = 1'b0;
    endtask

    task automatic clrc();
        clr_cnt = 1'b1; unlock = 1'b1; adv(1); clr_cnt = 1'b0; unlock = 1'b0;
    endtask

    task automatic clrf();
        clr_flag = 1'b1; unlock = 1'b1; adv(1); clr_flag = 1'b0; unlock = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        adv(3);
        rst_n = 1'b1;
        adv(1);
        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 rst", rst, 0);
        chk("R1 wake", wake, 0);
        chk("R1 flag", flag, 0);
        chk("R1 cnt", cnt, 0);

        // R2 locked control write ignored
        en_in = 1'b1; sel_in = 3'd7; cfg_wr = 1'b1; unlock = 1'b0;
        adv(1); cfg_wr = 1'b0;
        adv(5);
        chk("R2 locked cfg", cnt, 0);

        // R3 tick gating, select 7 (512 ticks)
        cfg(1, 1, 1, 7);
        for (int k = 0; k < 10; k++) begin
            tick = 1'b1; adv(1); tick = 1'b0; adv(1);
        end
        tick = 1'b1;
        chk("R3 gated count", cnt, 10);
        adv(5);
        chk("R3 count", cnt, 15);
        // R2 locked count clear ignored
        clr_cnt = 1'b1; adv(1); clr_cnt = 1'b0;
        chk("R2 locked clr_cnt", cnt, 16);

        // R4/R6 sweep over all selects
        for (int s = 0; s < 8; s++) begin
            int L;
            L = 1 << (BASE + STEP * s);
            cfg(0, 1, 1, s);
            clrf();
            cfg(1, 1, 1, s);
            adv(L - 1);
            chk($sformatf("R4 sel%0d cnt before", s), cnt, L - 1);
            chk($sformatf("R4 sel%0d flag before", s), flag, 0);
            adv(1);
            chk($sformatf("R4 sel%0d flag", s), flag, 1);
            chk($sformatf("R4 sel%0d wake", s), wake, 1);
            chk($sformatf("R5 sel%0d irq", s), irq, 1);
            chk($sformatf("R4 sel%0d cnt zero", s), cnt, 0);
            adv(1);
            chk($sformatf("R4 sel%0d wake once", s), wake, 0);
            adv(G - 2);
            chk($sformatf("R6 sel%0d rst early", s), rst, 0);
            adv(1);
            chk($sformatf("R6 sel%0d rst start", s), rst, 1);
            adv(RL - 1);
            chk($sformatf("R6 sel%0d rst hold", s), rst, 1);
            adv(1);
            chk($sformatf("R6 sel%0d rst end", s), rst, 0);
            adv(3);
            chk($sformatf("R6 sel%0d recount", s), cnt, 3);
            chk($sformatf("R6 sel%0d flag kept", s), flag, 1);
        end

        // R2 locked flag clear ignored
        clr_flag = 1'b1; adv(1); clr_flag = 1'b0;
        chk("R2 locked clr_flag", flag, 1);

        // R5 irq masked, set wins over clear (sel 0: 4 ticks)
        cfg(0, 0, 0, 0);
        clrf();
        cfg(1, 0, 0, 0);
        adv(4);
        chk("R5 flag masked", flag, 1);
        chk("R5 irq masked", irq, 0);
        clrc();
        chk("R8 clr keeps flag", flag, 1);
        clrf();
        chk("R5 flag cleared", flag, 0);
        adv(2);
        chk("R3 cnt before collide", cnt, 3);
        clr_flag = 1'b1; unlock = 1'b1; adv(1); clr_flag = 1'b0; unlock = 1'b0;
        chk("R5 set wins", flag, 1);

        // R7 reset disabled, then enabled late
        adv(G + 5);
        chk("R7 no reset", rst, 0);
        cfg(1, 0, 1, 0);
        chk("R7 write edge", rst, 0);
        adv(1);
        chk("R7 late reset", rst, 1);
        adv(RL);
        chk("R7 reset ends", rst, 0);

        // R8 clear inside grace window
        cfg(0, 1, 1, 0);
        clrf();
        cfg(1, 1, 1, 0);
        adv(4);
        chk("R8 timeout", flag, 1);
        adv(5);
        clrc();
        adv(G);
        chk("R8 grace cleared", rst, 0);

        // R8 clear before timeout, priority over tick (sel 1: 8 ticks)
        cfg(1, 1, 1, 1);
        chk("R9 sel change restart", cnt, 0);
        clrf();
        adv(5);
        chk("R3 cnt6", cnt, 6);
        clrc();
        chk("R8 clr over tick", cnt, 0);
        adv(7);
        chk("R8 cnt7", cnt, 7);
        chk("R8 no early timeout", flag, 0);
        adv(1);
        chk("R8 new timeout", flag, 1);

        // R9 same select keeps count
        clrc();
        adv(3);
        cfg(1, 1, 1, 1);
        chk("R9 same sel", cnt, 4);
        cfg(1, 1, 1, 2);
        chk("R9 new sel", cnt, 0);

        // R10 disable inside grace window (sel 2: 16 ticks)
        clrf();
        adv(15);
        chk("R4 sel2 timeout", flag, 1);
        adv(10);
        cfg(0, 1, 1, 2);
        chk("R10 idle cnt", cnt, 0);
        adv(G + 5);
        chk("R10 no reset", rst, 0);
        chk("R10 cnt held", cnt, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule